// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit descriptors kept in system memory. Host and engine pass each descriptor back and forth through an ownership flag in its status half-word. The engine does nothing until software writes a poll-demand command. It then reads the descriptor at its current pointer. If the engine owns that descriptor, it fetches the buffer address and the next-descriptor link, hands the frame to a frame sender and waits for the sender to report completion. It then writes the status back with the ownership flag cleared and raises a transmit-finished interrupt flag. Finally it moves to the linked descriptor and repeats. It stops, parked on the current descriptor, as soon as it reads one that the host still owns.

Software programs the ring base through two 16-bit register writes. A MAC-reset command moves the current pointer back to that base and idles the engine. The memory port moves one 32-bit word per request/acknowledge handshake. Moving the frame data itself is left to the frame sender.

Top module: `txring_fetcher`

## Requirements
- R1: After reset the block makes no memory request, does not pulse txStart, and irqStatus reads 0. The current pointer is 0.
- R2: A register write to address 2 with bit 0 of the data set is a poll demand, and fetching starts at the current pointer. A write to address 2 with bit 0 clear starts nothing. Without a poll demand the block stays idle even if descriptors are engine-owned.
- R3: A descriptor has three 32-bit words. The word at offset 0 holds status in bits 15:0 and length in bits 31:16. The word at offset 4 is the buffer address and the word at offset 8 is the next-descriptor address. The word at offset 0 is read first. The other two are read only when status bit 15 (engine owns) is set.
- R4: If the word at offset 0 has bit 15 clear, the block starts no frame, writes nothing and goes idle with its pointer still on that descriptor. A later poll demand re-reads the same descriptor.
- R5: For an engine-owned descriptor, txStart pulses for exactly one cycle. At the same time txBufAddr carries the buffer address and txLen carries the length, or 60 if the length is below 60.
- R6: Only after txDone does the block write the word at offset 0 back, with bit 15 cleared and all other bits unchanged. Completing the write sets bit 4 of irqStatus.
- R7: After a write-back the pointer follows the next-descriptor address with its low 5 bits forced to 0 (32-byte alignment). Processing continues until a host-owned descriptor is met.
- R8: Register address 0 loads base bits 15:0 (data bits 4:0 ignored) and address 1 loads base bits 31:16. Writing the base does not move the pointer. A write to address 3 with bit 0 set (MAC reset) sets the pointer to the base and returns the block to idle.
- R9: A write to address 4 clears each irqStatus bit whose data bit is 1. If a new completion happens in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 base low, 1 base high, 2 poll, 3 control, 4 interrupt clear) |
| regWdata | input | 16 | Register write data |
| memReq | output | 1 | Memory access request, held until memAck |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address of the memory word |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access complete |
| txStart | output | 1 | One-cycle frame start to the frame sender |
| txBufAddr | output | 32 | Frame buffer address |
| txLen | output | 16 | Frame length after the minimum-length rule |
| txDone | input | 1 | Frame sender finished the frame |
| irqStatus | output | 16 | Interrupt status, bit 4 = transmit finished |

## Verification
On every cycle the assertions check these things: txStart lasts one cycle, the length handed out never falls below the minimum, and memory addresses stay on descriptor word offsets. They also check that every write-back carries a cleared ownership bit and that the finished flag rises only right after a completed write, and that a MAC reset stops memory traffic. Other behaviours can only be shown by the scenarios. These are: whole-ring traversal with wrap, parking on a host-owned descriptor and re-reading it on the next poll, and rejection of a poll word without bit 0. The scenarios also cover masking of an unaligned next link, and the return to a base whose two halves were written separately.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT = 15;
  localparam int IRQ_TXDONE_BIT = 4;

  typedef enum logic [2:0] {
    REG_BASE_LO = 3'd0,
    REG_BASE_HI = 3'd1,
    REG_POLL    = 3'd2,
    REG_CTRL    = 3'd3,
    REG_IRQCLR  = 3'd4
  } regAddr_e;

  // word index inside a descriptor; byte offset is index * 4
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_NEXT = 2'd2
  } wordSel_e;

  typedef struct packed {
    logic     ldStatus;
    logic     ldBuf;
    logic     ldNext;
    logic     advance;
    logic     rewind;
    logic     setIrq;
    wordSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pollHit,
  input  logic   macRst,
  input  logic   memAck,
  input  logic   ownerSet,
  input  logic   txDone,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   txStart
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_BUF, S_RD_NEXT, S_START, S_WAIT, S_WB
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN)       state <= S_IDLE;
    else if (macRst) state <= S_IDLE;
    else             state <= nxt;
  end

  always_comb begin
    nxt     = state;
    ctl     = '0;
    ctl.sel = SEL_STAT;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txStart = 1'b0;
    ctl.rewind = macRst;
    unique case (state)
      S_IDLE: if (pollHit) nxt = S_RD_STAT;
      S_RD_STAT: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.ldStatus = 1'b1;
          nxt = ownerSet ? S_RD_BUF : S_IDLE;
        end
      end
      S_RD_BUF: begin
        memReq  = 1'b1;
        ctl.sel = SEL_BUF;
        if (memAck) begin
          ctl.ldBuf = 1'b1;
          nxt = S_RD_NEXT;
        end
      end
      S_RD_NEXT: begin
        memReq  = 1'b1;
        ctl.sel = SEL_NEXT;
        if (memAck) begin
          ctl.ldNext = 1'b1;
          nxt = S_START;
        end
      end
      S_START: begin
        txStart = 1'b1;
        nxt = S_WAIT;
      end
      S_WAIT: if (txDone) nxt = S_WB;
      S_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          ctl.setIrq  = 1'b1;
          ctl.advance = 1'b1;
          nxt = S_RD_STAT;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R5: the start strobe never lasts two cycles
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R8: a MAC reset leaves no memory traffic or frame start behind it
  p_rst_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    macRst |=> (!memReq && !txStart));
endmodule

// File: rtl/txr_dp.sv
module txr_dp
  import txr_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int ALIGN_W = 5,
  parameter int MIN_LEN = 60,
  localparam int ADDR_W = 2 * REG_W,
  localparam int WORD_W = 2 * REG_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              baseLoWe,
  input  logic              baseHiWe,
  input  logic              irqClrWe,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReq,
  input  logic              memWe,
  input  logic              memAck,
  input  logic              txStart,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] txBufAddr,
  output logic [REG_W-1:0]  txLen,
  output logic [REG_W-1:0]  irqStatus
);
  localparam logic [REG_W-1:0] MIN_LEN_V = REG_W'(MIN_LEN);

  logic [ADDR_W-1:0] baseAddr, curPtr, bufAddr, nextPtr;
  logic [WORD_W-1:0] statWord;
  logic [REG_W-1:0]  lenField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
    end else begin
      if (baseLoWe) baseAddr[REG_W-1:0] <= {regWdata[REG_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      if (baseHiWe) baseAddr[ADDR_W-1:REG_W] <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            curPtr <= '0;
    else if (ctl.rewind)  curPtr <= baseAddr;
    else if (ctl.advance) curPtr <= nextPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statWord <= '0;
      bufAddr  <= '0;
      nextPtr  <= '0;
    end else begin
      if (ctl.ldStatus) statWord <= memRdata;
      if (ctl.ldBuf)    bufAddr  <= memRdata;
      if (ctl.ldNext)   nextPtr  <= {memRdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStatus <= '0;
    end else begin
      for (int b = 0; b < REG_W; b++) begin
        if (b == IRQ_TXDONE_BIT && ctl.setIrq) irqStatus[b] <= 1'b1;
        else if (irqClrWe && regWdata[b])      irqStatus[b] <= 1'b0;
      end
    end
  end

  assign memAddr   = curPtr + {{(ADDR_W-4){1'b0}}, ctl.sel, 2'b00};
  assign lenField  = statWord[WORD_W-1:REG_W];
  assign txLen     = (lenField < MIN_LEN_V) ? MIN_LEN_V : lenField;
  assign txBufAddr = bufAddr;
  always_comb begin
    memWdata = statWord;
    memWdata[OWN_BIT] = 1'b0;
  end

  // R5: the sender is never told a length below the minimum
  p_min_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txLen >= MIN_LEN_V));

  // R3: memory traffic only touches word offsets 0, 4 and 8 of a descriptor
  p_desc_offset_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00 && memAddr[ALIGN_W-1:0] <= 8));

  // R6: a write-back always hands the descriptor to the host
  p_wb_owner_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !memWdata[OWN_BIT]);

  // R6: the finished flag rises only right after a completed write
  p_irq_after_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[IRQ_TXDONE_BIT]) |-> $past(memReq && memWe && memAck));
endmodule

// File: rtl/txring_fetcher.sv
module txring_fetcher
  import txr_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int ALIGN_W = 5,
  parameter int MIN_LEN = 60
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        txStart,
  output logic [31:0] txBufAddr,
  output logic [15:0] txLen,
  input  logic        txDone,
  output logic [15:0] irqStatus
);
  dpCtl_t ctl;
  logic pollHit, macRst, baseLoWe, baseHiWe, irqClrWe;

  assign pollHit  = regWe && regAddr == REG_POLL && regWdata[0];
  assign macRst   = regWe && regAddr == REG_CTRL && regWdata[0];
  assign baseLoWe = regWe && regAddr == REG_BASE_LO;
  assign baseHiWe = regWe && regAddr == REG_BASE_HI;
  assign irqClrWe = regWe && regAddr == REG_IRQCLR;

  txr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pollHit(pollHit), .macRst(macRst),
    .memAck(memAck), .ownerSet(memRdata[OWN_BIT]), .txDone(txDone),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .txStart(txStart)
  );

  txr_dp #(.REG_W(REG_W), .ALIGN_W(ALIGN_W), .MIN_LEN(MIN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .baseLoWe(baseLoWe), .baseHiWe(baseHiWe), .irqClrWe(irqClrWe),
    .regWdata(regWdata), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAck(memAck), .txStart(txStart),
    .memAddr(memAddr), .memWdata(memWdata),
    .txBufAddr(txBufAddr), .txLen(txLen), .irqStatus(irqStatus)
  );
endmodule

// File: tb/txring_fetcher_tb.sv
module txring_fetcher_tb_top;
  logic clk = 0, rstN = 0;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [15:0] regWdata = 0;
  logic memReq, memWe, memAck = 0, txStart, txDone = 0;
  logic [31:0] memAddr, memWdata, memRdata = 0, txBufAddr;
  logic [15:0] txLen, irqStatus;

  always #5 clk = ~clk;

  txring_fetcher dut_i (.*);

  logic [31:0] mem [0:255];
  logic [31:0] modelMem [0:255];
  logic [63:0] expStartQ[$];
  logic [63:0] expWrQ[$];
  int nChecks = 0, nFails = 0;
  int reqSeen = 0, startSeen = 0, wrSeen = 0, sendCnt = 0;
  logic [31:0] modelPtr = 0, modelBase = 0;
  logic finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (!rstN) memAck <= 0;
    else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        memRdata <= mem[memAddr[9:2]];
        if (memWe) mem[memAddr[9:2]] <= memWdata;
      end
    end
  end

  // frame sender stub: done after len/4 cycles
  always @(posedge clk) begin
    if (txStart) sendCnt <= int'(txLen) / 4;
    else if (sendCnt > 0) sendCnt <= sendCnt - 1;
    txDone <= (sendCnt == 1) && !txStart;
  end

  // per-cycle comparison against the model's expected events
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memReq && !memAck) reqSeen++;
      if (txStart) begin
        startSeen++;
        if (expStartQ.size() == 0) check(0, "R5 unexpected start", {txBufAddr, 16'h0, txLen}, 64'h0);
        else begin
          logic [63:0] e;
          e = expStartQ.pop_front();
          check({txBufAddr, 16'h0, txLen} == e, "R5 start buf/len", {txBufAddr, 16'h0, txLen}, e);
        end
      end
      if (memReq && memWe && !memAck) begin
        wrSeen++;
        if (expWrQ.size() == 0) check(0, "R6 unexpected write", {memAddr, memWdata}, 64'h0);
        else begin
          logic [63:0] e;
          e = expWrQ.pop_front();
          check({memAddr, memWdata} == e, "R6 write-back", {memAddr, memWdata}, e);
        end
      end
    end
  end

  task automatic putDesc(input logic [31:0] a, input logic [15:0] st, input logic [15:0] len,
                         input logic [31:0] buff, input logic [31:0] nxt);
    mem[a[9:2]] = {len, st};           modelMem[a[9:2]] = {len, st};
    mem[a[9:2] + 1] = buff;            modelMem[a[9:2] + 1] = buff;
    mem[a[9:2] + 2] = nxt;             modelMem[a[9:2] + 2] = nxt;
  endtask

  task automatic setOwner(input logic [31:0] a);
    mem[a[9:2]][15] = 1'b1;
    modelMem[a[9:2]][15] = 1'b1;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  // behavioural ring walk from the model pointer
  task automatic modelRun();
    for (int k = 0; k < 64; k++) begin
      logic [31:0] w0;
      logic [15:0] l;
      w0 = modelMem[modelPtr[9:2]];
      if (!w0[15]) break;
      l = (w0[31:16] < 16'd60) ? 16'd60 : w0[31:16];
      expStartQ.push_back({modelMem[modelPtr[9:2] + 1], 16'h0, l});
      w0[15] = 1'b0;
      expWrQ.push_back({modelPtr, w0});
      modelMem[modelPtr[9:2]] = w0;
      modelPtr = modelMem[modelPtr[9:2] + 2] & 32'hFFFF_FFE0;
    end
  endtask

  task automatic waitDrain();
    int t = 0;
    while ((expStartQ.size() != 0 || expWrQ.size() != 0) && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (30) @(negedge clk);
    check(expStartQ.size() == 0 && expWrQ.size() == 0, "R7 ring fully walked",
          64'(expStartQ.size() + expWrQ.size()), 64'h0);
  endtask

  task automatic pollRun();
    regWrite(3'd2, 16'h0001);
    modelRun();
    waitDrain();
  endtask

  task automatic checkMem(input string req);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== modelMem[i]) check(0, req, 64'(mem[i]), 64'(modelMem[i]));
    nChecks++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int r0, s0, w0;
    for (int i = 0; i < 256; i++) begin mem[i] = 0; modelMem[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!memReq && !txStart && irqStatus == 0, "R1 reset state", {memReq, txStart, irqStatus}, 0);

    // three-entry ring at 0x100, one short frame
    putDesc(32'h100, 16'h8000, 16'd100, 32'hA000_0000, 32'h120);
    putDesc(32'h120, 16'h8000, 16'd20,  32'hA000_1000, 32'h140);
    putDesc(32'h140, 16'h8000, 16'd60,  32'hA000_2000, 32'h100);
    regWrite(3'd0, 16'h0100);
    regWrite(3'd1, 16'h0000);
    regWrite(3'd3, 16'h0001);
    modelBase = 32'h100; modelPtr = modelBase;

    // R2 no poll, then a poll word without bit 0
    r0 = reqSeen;
    repeat (40) @(negedge clk);
    check(reqSeen == r0, "R2 idle without poll", 64'(reqSeen), 64'(r0));
    regWrite(3'd2, 16'h0002);
    repeat (40) @(negedge clk);
    check(reqSeen == r0, "R2 poll without bit0", 64'(reqSeen), 64'(r0));

    // R5 R6 R7 full walk with wrap
    pollRun();
    check(irqStatus[4] == 1'b1, "R6 finished flag", 64'(irqStatus), 64'h10);
    checkMem("R6 owner cleared in memory");

    // R9 clear
    regWrite(3'd4, 16'h0010);
    @(negedge clk);
    check(irqStatus == 0, "R9 interrupt clear", 64'(irqStatus), 0);

    // R4 host-owned: read happens, no start or write
    r0 = reqSeen; s0 = startSeen; w0 = wrSeen;
    regWrite(3'd2, 16'h0001);
    repeat (40) @(negedge clk);
    check(reqSeen == r0 + 1, "R4 status read only", 64'(reqSeen), 64'(r0 + 1));
    check(startSeen == s0 && wrSeen == w0, "R4 no start or write", 64'(startSeen), 64'(s0));
    check(irqStatus == 0, "R4 flag untouched", 64'(irqStatus), 0);

    // R7 unaligned link is masked
    putDesc(32'h100, 16'h8000, 16'd64, 32'hB000_0000, 32'h12C);
    pollRun();
    check(modelPtr == 32'h120, "R7 masked link", 64'(modelPtr), 64'h120);

    // R4 engine parked at 0x120: owning it and polling resumes there
    setOwner(32'h120);
    pollRun();
    checkMem("R4 resume at parked descriptor");

    // R8 base halves with low bits ignored, then MAC reset rewinds
    putDesc(32'h100, 16'h8000, 16'd200, 32'hC000_0000, 32'h140);
    regWrite(3'd0, 16'h0105);
    regWrite(3'd1, 16'h0001);
    r0 = reqSeen;
    regWrite(3'd2, 16'h0001);
    repeat (40) @(negedge clk);
    check(startSeen == s0 + 2, "R8 base write does not move pointer", 64'(startSeen), 64'(s0 + 2));
    regWrite(3'd3, 16'h0001);
    modelBase = 32'h0001_0100; modelPtr = modelBase;
    pollRun();
    check(irqStatus[4], "R8 frame after rewind", 64'(irqStatus), 64'h10);
    checkMem("R8 memory after rewind");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule